// File: doc/BRIEF.md
# Subtract-and-Branch Processor Core

This block is a small processor core with a single instruction and no opcode. Every instruction word holds three data-memory addresses. Executing a word subtracts one data byte from another and writes the difference back over the second byte. The core then either jumps to the third address or moves on to the next word. Arithmetic is 8-bit two's complement, and overflow is not detected.

The core has its own instruction store and its own data store. Both are filled through write-only load ports while the run enable is low. Raising the run enable starts execution from address 1, which is the first address after reset. Address 0 acts as a stop location. When the core fetches from it, the core raises a halted flag and holds there until reset. The program counter and the halted flag are the only outputs, so software uses branches to report results.

Top module: `subleq_core`

## Requirements
- R1: After reset the program counter reads 1 and the halted flag reads 0. The core stays in a one-cycle post-reset state before its first fetch.
- R2: An instruction word is {a, b, c}, with a in bits [23:16], b in bits [15:8] and c in bits [7:0]. Each field is a data or instruction address.
- R3: Executing {a, b, c} writes (data[b] - data[a]) mod 256 into data[b].
- R4: When that 8-bit difference is zero or has bit 7 set, the next program counter is c. Otherwise the next program counter is the current value plus one.
- R5: Overflow is ignored. The branch decision uses only the truncated 8-bit difference, for example 127 - (-1) gives -128 and the branch is taken.
- R6: Each instruction takes one fetch cycle and then one execute cycle. The program counter changes only at the end of execute. With run enable held high from reset, the first change comes 3 cycles after run enable rises, and each later change comes 2 cycles after the previous one.
- R7: A fetch at program counter 0 sets the halted flag. The flag and a program counter of 0 then persist until reset.
- R8: While run enable is low, the program counter and the sequencer hold. Load-port writes still store into either memory.
- R9: The increment wraps modulo 256: falling through at address 255 leads to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable |
| imem_we_i | input | 1 | Instruction store load strobe |
| imem_addr_i | input | 8 | Instruction store load address |
| imem_wdata_i | input | 24 | Instruction word to load |
| dmem_we_i | input | 1 | Data store load strobe |
| dmem_addr_i | input | 8 | Data store load address |
| dmem_wdata_i | input | 8 | Data byte to load |
| pc_o | output | 8 | Program counter |
| halted_o | output | 1 | Halted flag |

## Verification
The hardest effect to observe is the value written back into data memory, because no port reads that memory. The bench runs a fixed program for each operand pair. The program first branches one way or the other on the computed difference. It then applies two more subtractions that halt the core only if the stored byte equals the expected difference exactly; any other value falls into a self-loop. The bench sweeps every minuend against a set of subtrahends that includes the sign-boundary and overflow values.

// File: rtl/subleq_pkg.sv
package subleq_pkg;
  typedef enum logic [1:0] {
    ST_POST  = 2'b00,
    ST_FETCH = 2'b01,
    ST_EXEC  = 2'b10,
    ST_SPARE = 2'b11
  } seq_state_e;
endpackage

// File: rtl/subleq_alu.sv
module subleq_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] sub_i,
  output logic [DW-1:0] diff_o,
  output logic          leq_o
);
  // two's complement subtract, carry-out dropped
  assign diff_o = min_i + ~sub_i + {{(DW-1){1'b0}}, 1'b1};
  assign leq_o  = (diff_o == '0) | diff_o[DW-1];
endmodule

// File: rtl/subleq_dstore.sv
module subleq_dstore #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NRD = 2
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][DW-1:0]   rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end
endmodule

// File: rtl/subleq_istore.sv
module subleq_istore #(
  parameter int AW = 8,
  parameter int IW = 24
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [IW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/subleq_seq.sv
module subleq_seq
  import subleq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    case (state_q)
      ST_POST:  state_d = ST_FETCH;
      ST_FETCH: state_d = ST_EXEC;
      ST_EXEC:  state_d = ST_FETCH;
      default:  state_d = ST_POST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           state_q <= ST_POST;
    else if (adv_i || state_q == ST_SPARE) state_q <= state_d;
  end

  assign state_o = state_q;

  a_r6_fetch_then_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && state_q == ST_FETCH) |=> state_q == ST_EXEC);

  a_r8_hold_when_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && state_q != ST_SPARE) |=> $stable(state_q));
endmodule

// File: rtl/subleq_core.sv
module subleq_core
  import subleq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int IW = 3 * AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          imem_we_i,
  input  logic [AW-1:0] imem_addr_i,
  input  logic [IW-1:0] imem_wdata_i,
  input  logic          dmem_we_i,
  input  logic [AW-1:0] dmem_addr_i,
  input  logic [DW-1:0] dmem_wdata_i,
  output logic [AW-1:0] pc_o,
  output logic          halted_o
);
  localparam logic [AW-1:0] PC_BOOT = AW'(1);

  seq_state_e        state;
  logic [AW-1:0]     pc_q, pc_d;
  logic [IW-1:0]     ir_q, iword;
  logic              halted_q;
  logic              at_stop, adv, fire, leq;
  logic [AW-1:0]     op_a, op_b, op_c;
  logic [1:0][AW-1:0] rd_addr;
  logic [1:0][DW-1:0] rd_data;
  logic [DW-1:0]     diff;
  logic              d_we;
  logic [AW-1:0]     d_waddr;
  logic [DW-1:0]     d_wdata;

  assign op_a = ir_q[3*AW-1:2*AW];
  assign op_b = ir_q[2*AW-1:AW];
  assign op_c = ir_q[AW-1:0];

  assign at_stop = (state == ST_FETCH) && (pc_q == '0);
  assign adv     = run_i && !halted_q && !at_stop;
  assign fire    = adv && (state == ST_EXEC);

  subleq_seq i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .state_o(state)
  );

  subleq_istore #(.AW(AW), .IW(IW)) i_istore (
    .clk_i  (clk_i),
    .we_i   (imem_we_i),
    .waddr_i(imem_addr_i),
    .wdata_i(imem_wdata_i),
    .raddr_i(pc_q),
    .rdata_o(iword)
  );

  assign rd_addr[0] = op_a;
  assign rd_addr[1] = op_b;

  // load port wins over execute write-back
  assign d_we    = dmem_we_i | fire;
  assign d_waddr = dmem_we_i ? dmem_addr_i  : op_b;
  assign d_wdata = dmem_we_i ? dmem_wdata_i : diff;

  subleq_dstore #(.AW(AW), .DW(DW), .NRD(2)) i_dstore (
    .clk_i  (clk_i),
    .we_i   (d_we),
    .waddr_i(d_waddr),
    .wdata_i(d_wdata),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  subleq_alu #(.DW(DW)) i_alu (
    .min_i (rd_data[1]),
    .sub_i (rd_data[0]),
    .diff_o(diff),
    .leq_o (leq)
  );

  assign pc_d = leq ? op_c : pc_q + PC_BOOT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= PC_BOOT;
      ir_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      if (adv && state == ST_FETCH) ir_q <= iword;
      if (fire)                     pc_q <= pc_d;
      if (run_i && at_stop)         halted_q <= 1'b1;
    end
  end

  assign pc_o     = pc_q;
  assign halted_o = halted_q;

  a_r6_pc_only_on_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(pc_q));

  a_r7_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (halted_q && pc_q == '0));

  a_r4_equal_operands_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && rd_data[0] == rd_data[1]) |=> pc_q == $past(op_c));

  a_r8_idle_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_q));
endmodule

// File: tb/test_subleq_core.sv
module test_subleq_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic        imem_we_i = 1'b0;
  logic [7:0]  imem_addr_i = '0;
  logic [23:0] imem_wdata_i = '0;
  logic        dmem_we_i = 1'b0;
  logic [7:0]  dmem_addr_i = '0;
  logic [7:0]  dmem_wdata_i = '0;
  logic [7:0]  pc_o;
  logic        halted_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  localparam logic [7:0] XA = 8'd200, YB = 8'd201, MC = 8'd202, ONE = 8'd203, ZC = 8'd204;

  always #2 clk_i = ~clk_i;

  subleq_core i_subleq_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .imem_we_i(imem_we_i), .imem_addr_i(imem_addr_i), .imem_wdata_i(imem_wdata_i),
    .dmem_we_i(dmem_we_i), .dmem_addr_i(dmem_addr_i), .dmem_wdata_i(dmem_wdata_i),
    .pc_o(pc_o), .halted_o(halted_o)
  );

  always @(negedge clk_i) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    run_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr_i(input logic [7:0] a, input logic [23:0] w);
    @(negedge clk_i);
    imem_we_i = 1'b1; imem_addr_i = a; imem_wdata_i = w;
    @(negedge clk_i);
    imem_we_i = 1'b0;
  endtask

  task automatic wr_d(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk_i);
    dmem_we_i = 1'b1; dmem_addr_i = a; dmem_wdata_i = v;
    @(negedge clk_i);
    dmem_we_i = 1'b0;
  endtask

  function automatic logic [23:0] ins(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    return {a, b, c};  // R2 layout
  endfunction

  // counts negedges until pc_o differs from old; 0 if limit reached
  task automatic wait_pc(input logic [7:0] old, input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk_i);
      if (pc_o != old) begin n = i; break; end
    end
  endtask

  task automatic wait_halt(input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk_i);
      if (halted_o) begin ok = 1; break; end
    end
  endtask

  task automatic load_prog();
    wr_i(8'd1,  ins(XA, YB, 8'd8));
    wr_i(8'd2,  ins(MC, YB, 8'd20));
    wr_i(8'd3,  ins(ONE, YB, 8'd0));
    wr_i(8'd4,  ins(ZC, ZC, 8'd4));
    wr_i(8'd8,  ins(MC, YB, 8'd20));
    wr_i(8'd9,  ins(ONE, YB, 8'd0));
    wr_i(8'd10, ins(ZC, ZC, 8'd10));
    wr_i(8'd20, ins(ZC, ZC, 8'd20));
  endtask

  task automatic run_vec(input logic [7:0] x, input logic [7:0] y, input bit timing);
    logic [7:0] e;
    bit leq, ok;
    int n;
    e = y - x;
    leq = (e == 8'd0) || e[7];
    do_reset();
    wr_d(XA, x); wr_d(YB, y); wr_d(MC, e - 8'd1); wr_d(ONE, 8'd1); wr_d(ZC, 8'd0);
    @(negedge clk_i);
    run_i = 1'b1;
    wait_pc(8'd1, 10, n);
    if (timing) check("R6 first pc change delay", n, 3);
    check("R4/R5 branch target", pc_o, leq ? 8 : 2);
    if (timing) begin
      wait_pc(pc_o, 10, n);
      check("R6 next pc change delay", n, 2);
    end
    wait_halt(40, ok);
    check("R3 write-back value (halt reached)", ok, 1);
    check("R3 halt pc", pc_o, 0);
  endtask

  initial begin
    int n;
    bit ok;
    logic [7:0] ys [16] = '{8'd0, 8'd1, 8'd2, 8'd63, 8'd64, 8'd126, 8'd127, 8'd128,
                            8'd129, 8'd130, 8'd191, 8'd192, 8'd200, 8'd253, 8'd254, 8'd255};
    repeat (3) @(negedge clk_i);
    check("R1 pc during reset", pc_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 pc after reset", pc_o, 1);
    check("R1 halted after reset", halted_o, 0);

    // R8: loads while idle, pc holds
    load_prog();
    wr_d(ZC, 8'd0);
    repeat (5) @(negedge clk_i);
    check("R8 idle pc hold", pc_o, 1);
    check("R8 idle no halt", halted_o, 0);

    run_vec(8'd3, 8'd10, 1'b1);
    run_vec(8'd10, 8'd10, 1'b1);
    run_vec(8'hFF, 8'd127, 1'b0);  // R5 overflow to -128, taken
    run_vec(8'd1, 8'd128, 1'b0);   // R5 -128-1 = 127, not taken

    for (int xi = 0; xi < 256; xi++)
      for (int yi = 0; yi < 16; yi++)
        run_vec(8'(xi), ys[yi], 1'b0);

    // R9 wrap, R8 mid-run hold, R7 sticky halt
    wr_i(8'd1,   ins(ZC, ZC, 8'd255));
    wr_i(8'd255, ins(ZC, ONE, 8'd5));
    do_reset();
    wr_d(ZC, 8'd0); wr_d(ONE, 8'd1);
    @(negedge clk_i);
    run_i = 1'b1;
    wait_pc(8'd1, 10, n);
    check("R4 branch to 255", pc_o, 255);
    run_i = 1'b0;
    repeat (10) @(negedge clk_i);
    check("R8 run low holds pc", pc_o, 255);
    check("R8 run low no halt", halted_o, 0);
    run_i = 1'b1;
    wait_pc(8'd255, 10, n);
    check("R9 wrap to 0", pc_o, 0);
    wait_halt(10, ok);
    check("R7 halted at 0", ok, 1);
    repeat (20) @(negedge clk_i);
    check("R7 halted sticky", halted_o, 1);
    check("R7 pc stays 0", pc_o, 0);
    do_reset();
    check("R1 reset clears halt", halted_o, 0);
    check("R1 reset pc", pc_o, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule